// File: doc/BRIEF.md
# Clock Output Enable Gating

This block decides, for each of a set of clock output drivers (twelve by default), whether the driver runs or is parked. A parked driver is held at either a low or a high level. Several disable sources are combined, and any one of them that is not masked is enough to stop an output. The sources are an active-low output-enable pin, a global register disable, and the loss-of-lock status of the clock synthesizer. A select input picks whether the pin alone or the register bit as well governs disabling. The pin has the last word among the sources: when it is high, every output stops. A per-output force bit sits above all of that and keeps the feedback output of a zero-delay loop running whatever the other sources say.

Each output carries a local clock at half the block clock. The block gates that clock without glitches. A start or a stop only takes effect while the gated clock sits at the output's chosen parked level, so no shortened pulse ever leaves the block. The pin and the loss-of-lock input come from other clock domains and pass through two-flop synchronisers before use. All configuration inputs are treated as quasi-static register values.

Top module: `outclk_gate`

## Requirements
- R1: While reset is held and on the first cycle after it, every output reports the status code 2'b00 (disabled low) and its gated clock is 0.
- R2: With the pin low, no register disable and no loss of lock, every output reports status 2'b10 (running), and its gated clock changes value on every clock cycle.
- R3: When the synchronised active-low enable pin is high, every output without a force bit stops, whichever control source the select input picks and whatever the register disable bit holds.
- R4: With the select input at 1, setting the register disable bit stops every output without a force bit. With the select input at 0, the register disable bit has no effect.
- R5: Loss of lock stops an output when the global loss-of-lock mask is 0 and that output's loss-of-lock source enable bit (bit i for output i) is 1. A mask of 1, or a clear source enable bit, leaves the output running.
- R6: A stopped output reports status 2'b01 and holds its gated clock high when its park-level bit is 1. It reports status 2'b00 and holds its gated clock low when that bit is 0. Status 2'b11 never occurs.
- R7: An output whose force bit is set keeps running regardless of the pin, the register disable and loss of lock.
- R8: An output stops only in a cycle where its gated clock equals its park level, and it then holds that level. It restarts only from its park level, so the first value change after a start moves away from that level.
- R9: The pin and loss-of-lock inputs each pass through two flip-flops, so a change at either input cannot alter any output within the first two clock edges that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_pin_n | input | 1 | Active-low output-enable pin, asynchronous |
| lol_in | input | 1 | Loss-of-lock status, asynchronous, 1 = not locked |
| ctl_sel | input | 1 | 0: pin governs disabling; 1: register disable bit also applies |
| reg_disable | input | 1 | Global register disable, 1 = stop outputs (used when ctl_sel = 1) |
| lol_mask | input | 1 | 1 = loss of lock never stops an output |
| lol_src_en | input | N_OUT | Per output: 1 = loss of lock may stop this output |
| park_hi | input | N_OUT | Per output parked level: 1 = high, 0 = low |
| force_on | input | N_OUT | Per output: 1 = always running |
| out_status | output | 2*N_OUT | Field i at bits [2i+1:2i]: 00 stopped low, 01 stopped high, 10 running |
| gclk_out | output | N_OUT | Gated local clock for each output |

## Verification
The bench drives the disable sources one at a time and then in combination. It moves the pin alone under both settings of the select input, so the pin override can be told apart from register control. It raises loss of lock with and without the global mask and with one output's source enable cleared, which separates the global mask from the per-output gate. A mixed park-level pattern with one forced output shows whether each output parks at its own level and whether the force beats every source. Cycle-by-cycle watching of each stop and restart confirms that transitions happen only at the parked level and that the synchroniser delay holds.

// File: rtl/outclk_gate_pkg.sv
package outclk_gate_pkg;

  // Per-output status code reported on out_status
  typedef enum logic [1:0] {
    OST_OFF_LO = 2'b00,
    OST_OFF_HI = 2'b01,
    OST_RUN    = 2'b10
  } ost_e;

  localparam int OST_W    = 2;
  localparam int SYNC_STG = 2;

endpackage

// File: rtl/outclk_sync.sv
module outclk_sync #(
  parameter int W      = 1,
  parameter int STAGES = outclk_gate_pkg::SYNC_STG,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/outclk_src_comb.sv
module outclk_src_comb #(
  parameter int N_OUT = 12
) (
  input  logic             pin_dis,
  input  logic             lol_act,
  input  logic             ctl_sel,
  input  logic             reg_disable,
  input  logic             lol_mask,
  input  logic [N_OUT-1:0] lol_src_en,
  input  logic [N_OUT-1:0] force_on,
  output logic [N_OUT-1:0] dis_req
);

  // Shared sources: pin always, register only when selected
  logic shared_dis;
  assign shared_dis = pin_dis | (ctl_sel & reg_disable);

  for (genvar i = 0; i < N_OUT; i++) begin : g_src
    logic lol_dis;
    assign lol_dis    = lol_act & ~lol_mask & lol_src_en[i];
    assign dis_req[i] = ~force_on[i] & (shared_dis | lol_dis);
  end

endmodule

// File: rtl/outclk_chan.sv
module outclk_chan
  import outclk_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dis_req,
  input  logic       park_hi,
  output logic       run,
  output logic       gclk,
  output logic [1:0] status
);

  logic at_park;
  assign at_park = (gclk == park_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      gclk <= 1'b0;
    end else if (run) begin
      // stop only while sitting at the parked level
      if (dis_req && at_park) run  <= 1'b0;
      else                    gclk <= ~gclk;
    end else begin
      if (!dis_req && at_park) begin
        run  <= 1'b1;
        gclk <= ~gclk;
      end else begin
        gclk <= park_hi;
      end
    end
  end

  always_comb begin
    if (run)       status = OST_RUN;
    else if (gclk) status = OST_OFF_HI;
    else           status = OST_OFF_LO;
  end

endmodule

// File: rtl/outclk_gate.sv
module outclk_gate
  import outclk_gate_pkg::*;
#(
  parameter int N_OUT = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   oe_pin_n,
  input  logic                   lol_in,
  input  logic                   ctl_sel,
  input  logic                   reg_disable,
  input  logic                   lol_mask,
  input  logic [N_OUT-1:0]       lol_src_en,
  input  logic [N_OUT-1:0]       park_hi,
  input  logic [N_OUT-1:0]       force_on,
  output logic [OST_W*N_OUT-1:0] out_status,
  output logic [N_OUT-1:0]       gclk_out
);

  logic [1:0]       sync_q;
  logic [N_OUT-1:0] dis_req;
  logic [N_OUT-1:0] run_vec;

  // pin resets to its disabling level, lock status to locked
  outclk_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(2'b01)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({lol_in, oe_pin_n}),
    .d_sync  (sync_q)
  );

  outclk_src_comb #(.N_OUT(N_OUT)) u_src (
    .pin_dis     (sync_q[0]),
    .lol_act     (sync_q[1]),
    .ctl_sel     (ctl_sel),
    .reg_disable (reg_disable),
    .lol_mask    (lol_mask),
    .lol_src_en  (lol_src_en),
    .force_on    (force_on),
    .dis_req     (dis_req)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_chan
    outclk_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .dis_req (dis_req[i]),
      .park_hi (park_hi[i]),
      .run     (run_vec[i]),
      .gclk    (gclk_out[i]),
      .status  (out_status[OST_W*i +: OST_W])
    );
  end

endmodule

// File: rtl/outclk_gate_chk.sv
module outclk_gate_chk #(
  parameter int N_OUT = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_sel,
  input logic             reg_disable,
  input logic [N_OUT-1:0] park_hi,
  input logic [N_OUT-1:0] force_on,
  input logic [N_OUT-1:0] run_vec,
  input logic [N_OUT-1:0] gclk_out
);

  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    // R8: a stop leaves the clock at the level parked at that edge
    a_r8_stop_at_park: assert property (@(posedge clk) disable iff (rst || !seen)
      $fell(run_vec[i]) |-> gclk_out[i] == $past(park_hi[i]));

    // R8/R6: while stopped the clock follows the parked level only
    a_r8_hold_parked: assert property (@(posedge clk) disable iff (rst || !seen)
      (!run_vec[i] && $past(!run_vec[i])) |-> gclk_out[i] == $past(park_hi[i]));

    // R2: a running output changes value every cycle
    a_r2_toggle: assert property (@(posedge clk) disable iff (rst || !seen)
      (run_vec[i] && $past(run_vec[i])) |-> gclk_out[i] != $past(gclk_out[i]));

    // R7: a forced running output never stops
    a_r7_force_keeps: assert property (@(posedge clk) disable iff (rst || !seen)
      ($past(force_on[i]) && $past(run_vec[i])) |-> run_vec[i]);

    // R4: register disable keeps a stopped unforced output stopped
    a_r4_reg_holds_off: assert property (@(posedge clk) disable iff (rst || !seen)
      ($past(ctl_sel & reg_disable & ~force_on[i]) && $past(!run_vec[i])) |-> !run_vec[i]);
  end

endmodule

bind outclk_gate outclk_gate_chk #(.N_OUT(N_OUT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_sel     (ctl_sel),
  .reg_disable (reg_disable),
  .park_hi     (park_hi),
  .force_on    (force_on),
  .run_vec     (run_vec),
  .gclk_out    (gclk_out)
);

// File: tb/outclk_gate_tb.sv
module outclk_gate_tb;

  localparam int N = 12;

  logic           clk = 1'b0;
  logic           rst;
  logic           oe_pin_n, lol_in, ctl_sel, reg_disable, lol_mask;
  logic [N-1:0]   lol_src_en, park_hi, force_on;
  logic [2*N-1:0] out_status;
  logic [N-1:0]   gclk_out;

  int  n_chk  = 0;
  int  n_err  = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  outclk_gate #(.N_OUT(N)) u_dut (
    .clk(clk), .rst(rst), .oe_pin_n(oe_pin_n), .lol_in(lol_in),
    .ctl_sel(ctl_sel), .reg_disable(reg_disable), .lol_mask(lol_mask),
    .lol_src_en(lol_src_en), .park_hi(park_hi), .force_on(force_on),
    .out_status(out_status), .gclk_out(gclk_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [2*N-1:0] all_status(input logic [1:0] code);
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) v[2*i +: 2] = code;
    return v;
  endfunction

  // expected status for stopped outputs with a given park pattern
  function automatic logic [2*N-1:0] parked_status(input logic [N-1:0] pk,
                                                   input logic [N-1:0] running);
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++)
      v[2*i +: 2] = running[i] ? 2'b10 : {1'b0, pk[i]};
    return v;
  endfunction

  task automatic t_reset;
    rst = 1'b1; oe_pin_n = 1'b0; lol_in = 1'b0; ctl_sel = 1'b0;
    reg_disable = 1'b0; lol_mask = 1'b0; lol_src_en = '1;
    park_hi = '0; force_on = '0;
    cycles(4);
    check(out_status == all_status(2'b00), "R1 status in reset", out_status, all_status(2'b00));
    check(gclk_out == '0, "R1 clock in reset", gclk_out, 0);
    rst = 1'b0;
    cycles(1);
    check(out_status == all_status(2'b00), "R1 status after reset", out_status, all_status(2'b00));
  endtask

  task automatic t_run;
    logic [N-1:0] prev;
    cycles(6);
    check(out_status == all_status(2'b10), "R2 all running", out_status, all_status(2'b10));
    prev = gclk_out;
    cycles(1);
    check(gclk_out == ~prev, "R2 toggle", gclk_out, ~prev);
    prev = gclk_out;
    cycles(1);
    check(gclk_out == ~prev, "R2 toggle again", gclk_out, ~prev);
  endtask

  task automatic t_pin;
    oe_pin_n = 1'b1;
    // two edges pass through the synchroniser only
    cycles(2);
    check(out_status == all_status(2'b10), "R9 pin delayed", out_status, all_status(2'b10));
    cycles(5);
    check(out_status == all_status(2'b00), "R3 pin stops all", out_status, all_status(2'b00));
    check(gclk_out == '0, "R3 parked low", gclk_out, 0);
    ctl_sel = 1'b1; reg_disable = 1'b0;
    cycles(5);
    check(out_status == all_status(2'b00), "R3 pin beats register select", out_status, all_status(2'b00));
    ctl_sel = 1'b0; oe_pin_n = 1'b0;
    cycles(6);
    check(out_status == all_status(2'b10), "R3 pin release", out_status, all_status(2'b10));
  endtask

  task automatic t_reg;
    ctl_sel = 1'b1; reg_disable = 1'b1;
    cycles(4);
    check(out_status == all_status(2'b00), "R4 register stops", out_status, all_status(2'b00));
    ctl_sel = 1'b0;
    cycles(4);
    check(out_status == all_status(2'b10), "R4 register ignored", out_status, all_status(2'b10));
    reg_disable = 1'b0;
  endtask

  task automatic t_lol;
    logic [N-1:0] run_exp;
    lol_src_en = '1; lol_src_en[5] = 1'b0;
    lol_mask = 1'b0; lol_in = 1'b1;
    // synchroniser delay check for the loss-of-lock input
    cycles(2);
    check(out_status == all_status(2'b10), "R9 lol delayed", out_status, all_status(2'b10));
    cycles(5);
    run_exp = '0; run_exp[5] = 1'b1;
    check(out_status == parked_status('0, run_exp), "R5 lol stops unmasked", out_status,
          parked_status('0, run_exp));
    lol_mask = 1'b1;
    cycles(4);
    check(out_status == all_status(2'b10), "R5 lol masked", out_status, all_status(2'b10));
    lol_in = 1'b0; lol_mask = 1'b0; lol_src_en = '1;
    cycles(6);
  endtask

  task automatic t_park_force;
    logic [N-1:0] run_exp, prev;
    park_hi = 12'hA5A; force_on = '0; force_on[9] = 1'b1;
    oe_pin_n = 1'b1;
    cycles(8);
    run_exp = '0; run_exp[9] = 1'b1;
    check(out_status == parked_status(12'hA5A, run_exp), "R6 park levels", out_status,
          parked_status(12'hA5A, run_exp));
    check((gclk_out & ~run_exp) == (12'hA5A & ~run_exp), "R6 parked clocks", gclk_out & ~run_exp,
          12'hA5A & ~run_exp);
    ctl_sel = 1'b1; reg_disable = 1'b1; lol_in = 1'b1;
    cycles(4);
    check(out_status[19:18] == 2'b10, "R7 forced runs", out_status[19:18], 2'b10);
    prev = gclk_out;
    cycles(1);
    check(gclk_out[9] != prev[9], "R7 forced toggles", gclk_out[9], ~prev[9]);
    ctl_sel = 1'b0; reg_disable = 1'b0; lol_in = 1'b0; force_on = '0;
    oe_pin_n = 1'b0;
    cycles(8);
    check(out_status == all_status(2'b10), "R6 restart after park", out_status, all_status(2'b10));
  endtask

  task automatic t_edges;
    logic [N-1:0] prev_run, now_run, seen;
    prev_run = '1; seen = '0;
    oe_pin_n = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        now_run[i] = out_status[2*i+1];
        if (prev_run[i] && !now_run[i]) begin
          seen[i] = 1'b1;
          check(gclk_out[i] == park_hi[i], "R8 stop at park", gclk_out[i], park_hi[i]);
        end
      end
      prev_run = now_run;
    end
    check(seen == '1, "R8 every output stopped", seen, '1);
    seen = '0;
    oe_pin_n = 1'b0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        now_run[i] = out_status[2*i+1];
        if (!prev_run[i] && now_run[i]) begin
          seen[i] = 1'b1;
          check(gclk_out[i] != park_hi[i], "R8 start leaves park", gclk_out[i], ~park_hi[i]);
        end
      end
      prev_run = now_run;
    end
    check(seen == '1, "R8 every output restarted", seen, '1);
  endtask

  initial begin
    t_reset();
    t_run();
    t_pin();
    t_reg();
    t_lol();
    t_park_force();
    t_edges();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule